// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block carries out the hardware half of taking an interrupt in a small processor. It waits for an instruction boundary, and it starts only when a request is pending and interrupts are enabled. It then runs four steps that hand control to the interrupt's own vector entry. The vector table gives each interrupt number two adjacent words. The lower word receives the interrupted program counter. The upper word holds a jump to the service routine, and execution resumes there.

A mode input selects a second scheme that serves every interrupt number alike. In this mode the program counter is stored at address 0 and execution restarts at address 1, where one common routine works out the source. The sequencer latches the interrupt number, the mode and the program counter when it starts, so these inputs may change freely while it runs. It clears the enable flag as it starts, so it cannot start again until software sets the flag.

Top module: `irq_entry_seq`

## Requirements
- R1: While reset is held and in the cycle after it is released, `busy`, `mem_we`, `pc_load`, `fetch_go` and `int_enabled` are all 0, and `mem_addr`, `mem_wdata` and `pc_next` are 0.
- R2: `en_set` makes `int_enabled` 1 at the next clock edge and `en_clr` makes it 0. When both are high in the same cycle, the clear wins.
- R3: The sequence starts at a clock edge only if the block is idle, `instr_done`, `irq_pending` and `int_enabled` are all 1. `busy` is then 1 after that edge and stays 1 until the last step ends. If any of these conditions is 0, the block stays idle.
- R4: In step 0, `mem_we` is 1. `mem_addr` is the slot address, which is VEC_BASE + 2 × number, truncated to the address width. `mem_wdata` is 0.
- R5: In step 1, `mem_we` is 1. `mem_addr` still holds the slot address, and `mem_wdata` holds the `pc_in` value sampled at the start edge.
- R6: In step 2, `pc_load` is 1, `mem_we` is 0 and `pc_next` is the slot address + 1, truncated to the address width.
- R7: In step 3, `fetch_go` is 1 and the other strobes are 0. Outside their own steps, `mem_addr`, `mem_wdata` and `pc_next` read 0.
- R8: Each step lasts until a cycle with `mem_ack` = 1. Until that cycle, every output holds its value, and the block moves to the next step at the edge that ends it. The acknowledge that ends step 3 returns the block to idle.
- R9: When `shared_mode` is 1 at the start edge, the slot address is 0 and `pc_next` is 1, whatever the interrupt number. Changes to `irq_num`, `shared_mode` and `pc_in` after the start edge have no effect on that sequence.
- R10: The start edge clears `int_enabled`. Once the sequence ends, a request that is still pending cannot start a new sequence until `en_set` is pulsed again.
- R11: Slot and jump addresses wrap at the address width. With the default base 0xFFF0, number 8 gives slot 0x0000 and number 7 gives jump address 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_set | input | 1 | Sets the interrupt enable flag |
| en_clr | input | 1 | Clears the interrupt enable flag |
| shared_mode | input | 1 | 1 selects the common save slot at address 0 and restart at address 1 |
| irq_pending | input | 1 | An interrupt request is pending |
| irq_num | input | NUM_W | Number of the pending interrupt |
| instr_done | input | 1 | The current instruction completes in this cycle |
| pc_in | input | ADDR_W | Current program counter |
| mem_ack | input | 1 | Ends the current step |
| int_enabled | output | 1 | Interrupt enable flag |
| busy | output | 1 | The sequence is running (steps 0 to 3) |
| mem_addr | output | ADDR_W | Address of the vector slot |
| mem_we | output | 1 | Write request for the slot |
| mem_wdata | output | ADDR_W | Saved program counter |
| pc_load | output | 1 | Load the program counter from `pc_next` |
| pc_next | output | ADDR_W | New program counter value |
| fetch_go | output | 1 | Hand control back to instruction fetch |

## Verification
All outputs come straight from the step register, so a start condition held across a rising edge shows up one cycle later: `busy` is high, step 0 is on the outputs and `int_enabled` is low. The bench drives inputs at falling edges and samples at the next falling edge. Within a step, it checks every output in each waiting cycle and in the acknowledge cycle. At the falling edge after the acknowledge, it expects the next step's values, or the idle values after step 3. Rejected starts and the blocked re-entry are checked one falling edge after the edge that would have taken them.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SLOT  = 3'd1,
        ST_SAVE  = 3'd2,
        ST_JUMP  = 3'd3,
        ST_FETCH = 3'd4
    } step_e;

    typedef struct packed {
        logic show_addr;
        logic write;
        logic show_data;
        logic load_pc;
        logic to_fetch;
    } step_ctl_t;

    function automatic step_ctl_t ctl_of(step_e s);
        step_ctl_t c;
        c = '0;
        case (s)
            ST_SLOT:  begin c.show_addr = 1'b1; c.write = 1'b1; end
            ST_SAVE:  begin c.show_addr = 1'b1; c.write = 1'b1; c.show_data = 1'b1; end
            ST_JUMP:  c.load_pc = 1'b1;
            ST_FETCH: c.to_fetch = 1'b1;
            default:  c = '0;
        endcase
        return c;
    endfunction

    function automatic step_e next_of(step_e s);
        case (s)
            ST_SLOT:  return ST_SAVE;
            ST_SAVE:  return ST_JUMP;
            ST_JUMP:  return ST_FETCH;
            default:  return ST_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/irq_enable_flag.sv
module irq_enable_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    input  logic take_i,
    output logic flag_o
);
    always_ff @(posedge clk) begin
        if (rst)                  flag_o <= 1'b0;
        else if (take_i || clr_i) flag_o <= 1'b0;
        else if (set_i)           flag_o <= 1'b1;
    end

    // R10
    take_clears_flag_chk: assert property (@(posedge clk) disable iff (rst)
        take_i |=> !flag_o);

    // R2
    clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> !flag_o);
endmodule

// File: rtl/irq_vec_addr.sv
module irq_vec_addr #(
    parameter int                  ADDR_W   = 16,
    parameter int                  NUM_W    = 4,
    parameter logic [ADDR_W-1:0]   VEC_BASE = 16'hFFF0
) (
    input  logic [NUM_W-1:0]  num_i,
    input  logic              shared_i,
    output logic [ADDR_W-1:0] slot_o,
    output logic [ADDR_W-1:0] target_o
);
    localparam int OFS_W = NUM_W + 1;

    logic [OFS_W-1:0]  ofs_raw;
    logic [ADDR_W-1:0] ofs;

    always_comb begin
        ofs_raw  = {num_i, 1'b0};
        ofs      = ADDR_W'(ofs_raw);
        slot_o   = shared_i ? '0 : ADDR_W'(VEC_BASE + ofs);
        target_o = ADDR_W'(slot_o + ADDR_W'(1));
    end
endmodule

// File: rtl/irq_step_fsm.sv
module irq_step_fsm
    import irq_entry_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start_i,
    input  logic  ack_i,
    output step_e state_o,
    output logic  busy_o
);
    step_e state_q;

    always_ff @(posedge clk) begin
        if (rst)                             state_q <= ST_IDLE;
        else if (state_q == ST_IDLE) begin
            if (start_i)                     state_q <= ST_SLOT;
        end
        else if (ack_i)                      state_q <= next_of(state_q);
    end

    assign state_o = state_q;
    assign busy_o  = (state_q != ST_IDLE);

    // R8
    hold_without_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !ack_i) |=> $stable(state_q));

    // R8
    last_ack_idles_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FETCH && ack_i) |=> !busy_o);
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_entry_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter int                NUM_W    = 4,
    parameter logic [ADDR_W-1:0] VEC_BASE = 16'hFFF0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_set,
    input  logic              en_clr,
    input  logic              shared_mode,
    input  logic              irq_pending,
    input  logic [NUM_W-1:0]  irq_num,
    input  logic              instr_done,
    input  logic [ADDR_W-1:0] pc_in,
    input  logic              mem_ack,
    output logic              int_enabled,
    output logic              busy,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_wdata,
    output logic              pc_load,
    output logic [ADDR_W-1:0] pc_next,
    output logic              fetch_go
);
    step_e             state;
    step_ctl_t         ctl;
    logic              start;
    logic [NUM_W-1:0]  num_q;
    logic              shared_q;
    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] slot;
    logic [ADDR_W-1:0] target;

    assign start = (state == ST_IDLE) && instr_done && irq_pending && int_enabled;

    irq_enable_flag u_flag (
        .clk    (clk),
        .rst    (rst),
        .set_i  (en_set),
        .clr_i  (en_clr),
        .take_i (start),
        .flag_o (int_enabled)
    );

    irq_step_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .start_i (start),
        .ack_i   (mem_ack),
        .state_o (state),
        .busy_o  (busy)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            num_q    <= '0;
            shared_q <= 1'b0;
            pc_q     <= '0;
        end else if (start) begin
            num_q    <= irq_num;
            shared_q <= shared_mode;
            pc_q     <= pc_in;
        end
    end

    irq_vec_addr #(
        .ADDR_W   (ADDR_W),
        .NUM_W    (NUM_W),
        .VEC_BASE (VEC_BASE)
    ) u_addr (
        .num_i    (num_q),
        .shared_i (shared_q),
        .slot_o   (slot),
        .target_o (target)
    );

    always_comb begin
        ctl       = ctl_of(state);
        mem_addr  = ctl.show_addr ? slot   : '0;
        mem_we    = ctl.write;
        mem_wdata = ctl.show_data ? pc_q   : '0;
        pc_load   = ctl.load_pc;
        pc_next   = ctl.load_pc   ? target : '0;
        fetch_go  = ctl.to_fetch;
    end

    // R3
    start_sets_busy_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> (busy && mem_we && !int_enabled));

    // R7
    strobe_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_we, pc_load, fetch_go}));

    // R8
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_we && !mem_ack) |=> $stable(mem_addr));

    // R5
    save_follows_slot_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_we && !pc_load && mem_ack && (mem_wdata == '0) && $past(!busy)) |=> mem_we);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mem_we && !pc_load && !fetch_go));
endmodule

// File: tb/test_irq_entry_seq.sv
module test_irq_entry_seq;
    localparam int          AW   = 16;
    localparam int          NW   = 4;
    localparam logic [15:0] BASE = 16'hFFF0;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          en_set = 0, en_clr = 0, shared_mode = 0, irq_pending = 0, instr_done = 0, mem_ack = 0;
    logic [NW-1:0] irq_num = '0;
    logic [AW-1:0] pc_in = '0;
    logic          int_enabled, busy, mem_we, pc_load, fetch_go;
    logic [AW-1:0] mem_addr, mem_wdata, pc_next;

    int checks = 0;
    int errors = 0;

    irq_entry_seq #(.ADDR_W(AW), .NUM_W(NW), .VEC_BASE(BASE)) i_irq_entry_seq (
        .clk(clk), .rst(rst), .en_set(en_set), .en_clr(en_clr),
        .shared_mode(shared_mode), .irq_pending(irq_pending), .irq_num(irq_num),
        .instr_done(instr_done), .pc_in(pc_in), .mem_ack(mem_ack),
        .int_enabled(int_enabled), .busy(busy), .mem_addr(mem_addr), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .pc_load(pc_load), .pc_next(pc_next), .fetch_go(fetch_go)
    );

    always #10 clk = ~clk;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] exp_slot(logic [NW-1:0] n, logic sh);
        logic [AW-1:0] ofs;
        ofs = AW'({n, 1'b0});
        return sh ? '0 : AW'(BASE + ofs);
    endfunction

    task automatic chk_step(int s, logic [AW-1:0] slot, logic [AW-1:0] pc);
        chk("R3 busy", busy, 1);
        chk("R4/R5 mem_we", mem_we, (s < 2));
        chk("R4/R5 mem_addr", mem_addr, (s < 2) ? slot : '0);
        chk("R5 mem_wdata", mem_wdata, (s == 1) ? pc : '0);
        chk("R6 pc_load", pc_load, (s == 2));
        chk("R6 pc_next", pc_next, (s == 2) ? AW'(slot + 1) : '0);
        chk("R7 fetch_go", fetch_go, (s == 3));
    endtask

    task automatic chk_idle(string req);
        chk(req, {busy, mem_we, pc_load, fetch_go}, 0);
        chk(req, mem_addr | mem_wdata | pc_next, 0);
    endtask

    task automatic enable();
        en_set = 1; @(negedge clk); en_set = 0;
        chk("R2 set", int_enabled, 1);
    endtask

    task automatic run_entry(logic [NW-1:0] n, logic sh, logic [AW-1:0] pc, int maxw);
        logic [AW-1:0] slot;
        slot = exp_slot(n, sh);
        enable();
        irq_num = n; shared_mode = sh; pc_in = pc; irq_pending = 1; instr_done = 1;
        @(negedge clk);
        instr_done = 0;
        // R9: disturb latched inputs
        irq_num = ~n; shared_mode = ~sh; pc_in = ~pc;
        chk("R10 flag cleared", int_enabled, 0);
        for (int s = 0; s < 4; s++) begin
            int w;
            w = int'($urandom % (maxw + 1));
            repeat (w) begin
                instr_done = 1;
                chk_step(s, slot, pc);
                @(negedge clk);
                instr_done = 0;
            end
            mem_ack = 1;
            chk_step(s, slot, pc);
            @(negedge clk);
            mem_ack = 0;
        end
        chk_idle("R8 idle after step 3");
        // R10: still pending, enable cleared, no re-entry
        instr_done = 1;
        @(negedge clk);
        instr_done = 0;
        chk("R10 no re-entry", busy, 0);
        irq_pending = 0;
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        @(negedge clk);
        chk_idle("R1 in reset");
        chk("R1 flag", int_enabled, 0);
        repeat (2) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk_idle("R1 after reset");
        chk("R1 flag", int_enabled, 0);

        // R2: set and clear together -> clear wins
        enable();
        en_set = 1; en_clr = 1; @(negedge clk); en_set = 0; en_clr = 0;
        chk("R2 clear wins", int_enabled, 0);

        // R3: rejected starts
        irq_pending = 1; instr_done = 1; @(negedge clk);
        chk("R3 no start without enable", busy, 0);
        instr_done = 0;
        enable();
        @(negedge clk);
        chk("R3 no start without instr_done", busy, 0);
        irq_pending = 0; instr_done = 1; @(negedge clk);
        chk("R3 no start without pending", busy, 0);
        instr_done = 0;
        en_clr = 1; @(negedge clk); en_clr = 0;
        chk("R2 clear", int_enabled, 0);

        // directed
        run_entry(4'd0, 1'b0, 16'h1234, 0);
        run_entry(4'd3, 1'b0, 16'hABCD, 2);
        run_entry(4'd8, 1'b0, 16'h0042, 1);   // R11 slot wraps to 0x0000
        run_entry(4'd7, 1'b0, 16'h7777, 1);   // R11 jump 0xFFFF
        run_entry(4'd15, 1'b1, 16'hBEEF, 2);  // R9 shared mode
        run_entry(4'd5, 1'b1, 16'h0001, 0);   // R9

        for (int i = 0; i < 24; i++)
            run_entry(NW'($urandom), 1'($urandom), AW'($urandom), 3);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule